// File: doc/BRIEF.md
# Exclusive Access Monitor

This block gives a 32-bit processor data path load-exclusive and store-exclusive operations for building atomic read-modify-write sequences. It sits between the execute stage and a simple memory port. That port takes a read strobe at a clock edge and returns the word on `mem_rdata` during the following cycle.

A load-exclusive reads one word. It records the access address and the word it read as a reservation. A later store-exclusive to the same address reads the word again. It writes the new data only if memory still holds the recorded value, so it behaves like a compare-and-swap. The pass/fail outcome is not written straight to the destination. It is swapped into a one-bit result flag, which sits at bit 8 of an atomic-control word. The instruction receives the flag's previous value. A get-result operation swaps the flag with bit 0 of its source. Clear-exclusive drops the reservation.

Requests use a single valid strobe with a one-hot operation select. `done` pulses for one cycle when `rsp_data` and `align_fault` are valid. `busy` is high while a memory operation is still in flight.

Top module: `excl_monitor`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low, and the result flag is 0. The reservation address is 0xFFFFFFFF, so a store-exclusive to any aligned address fails without touching memory.
- R2: The operation select `req_op` uses these bits: bit 0 load, bit 1 store, bit 2 clear, bit 3 get. A load to an aligned address raises `mem_rd` in its request cycle. `done` follows two cycles after acceptance, with `rsp_data` equal to the word read. The load sets the reservation address and value.
- R3: For a load or store whose address has bits [1:0] not equal to zero, there is no memory access. `done` and `align_fault` rise together one cycle after the request, and `rsp_data` is 0. The reservation and the flag are unchanged.
- R4: A clear sets the reservation address to 0xFFFFFFFF. `done` follows one cycle later, with `rsp_data` equal to 0.
- R5: A store whose address differs from the reservation address makes no memory access. It completes one cycle later with `rsp_data` equal to the previous flag, and it sets the flag to 0.
- R6: A store whose address matches the reservation reads the word. In the next cycle it writes the store data only if that word equals the reservation value. It completes two cycles after acceptance with `rsp_data` equal to the previous flag, and it sets the flag to 1 on a write and to 0 otherwise.
- R7: After any store whose address matched, the reservation address is 0xFFFFFFFF, whether or not the store wrote. When the compare fails, the reservation value becomes the word that was read.
- R8: A get returns the previous flag in `rsp_data` bit 0, with all other bits 0, and loads the flag from bit 0 of `req_data`. It completes one cycle later.
- R9: `busy` is high in the cycle after a memory read is issued. Requests presented while `busy` is high are ignored.
- R10: A request whose `req_op` is not one-hot is ignored: it causes no memory access, no `done` and no state change.
- R11: Each accepted operation produces exactly one `done` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | One-hot select: 0 load, 1 store, 2 clear, 3 get |
| req_addr | input | 32 | Byte address for load and store |
| req_data | input | 32 | Store data, or get source (bit 0) |
| busy | output | 1 | Memory operation in flight |
| done | output | 1 | Result valid pulse |
| rsp_data | output | 32 | Load data or previous flag |
| align_fault | output | 1 | Misaligned access, valid with done |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |

## Verification
A corrupted reservation address stays hidden until the next store-exclusive. There it appears either as a missing `mem_rd` in the request cycle or as an unexpected one, so the fault is seen at the first store after the bad update. A stale reservation value appears one cycle later, as a wrong `mem_wr` decision and a wrong flag. The flag itself can only be observed as bit 0 of the response to the next store or get. For that reason the random sequence mixes gets and stores often, so that a wrong flag is seen within a few operations.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rsp_data,
  output logic          align_fault,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OP_LD = 0, OP_ST = 1, OP_CLR = 2, OP_GET = 3;
  localparam logic [AW-1:0] NO_RES = '1;

  typedef enum logic [1:0] {S_IDLE, S_LD, S_ST} state_t;

  state_t        state;
  logic [AW-1:0] res_addr, op_addr;
  logic [DW-1:0] res_val, op_data;
  logic          flag;

  wire one_hot = (req_op != 4'd0) && ((req_op & (req_op - 4'd1)) == 4'd0);
  wire accept  = req_valid && (state == S_IDLE) && one_hot;
  wire misal   = |req_addr[1:0];
  wire is_mem  = req_op[OP_LD] || req_op[OP_ST];
  wire hit     = (req_addr == res_addr);
  wire same    = (mem_rdata == res_val);

  assign busy      = (state != S_IDLE);
  assign mem_rd    = accept && !misal && (req_op[OP_LD] || (req_op[OP_ST] && hit));
  assign mem_wr    = (state == S_ST) && same;
  assign mem_addr  = (state == S_IDLE) ? req_addr : op_addr;
  assign mem_wdata = op_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      res_addr    <= NO_RES;
      res_val     <= '0;
      flag        <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
      done        <= 1'b0;
      align_fault <= 1'b0;
      rsp_data    <= '0;
    end else begin
      done        <= 1'b0;
      align_fault <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          op_addr <= req_addr;
          op_data <= req_data;
          if (is_mem && misal) begin
            done        <= 1'b1;
            align_fault <= 1'b1;
            rsp_data    <= '0;
          end else if (req_op[OP_LD]) begin
            state <= S_LD;
          end else if (req_op[OP_ST]) begin
            if (hit) state <= S_ST;
            else begin
              done     <= 1'b1;
              rsp_data <= DW'(flag);
              flag     <= 1'b0;
            end
          end else if (req_op[OP_CLR]) begin
            res_addr <= NO_RES;
            done     <= 1'b1;
            rsp_data <= '0;
          end else begin
            done     <= 1'b1;
            rsp_data <= DW'(flag);
            flag     <= req_data[0];
          end
        end
        S_LD: begin
          res_addr <= op_addr;
          res_val  <= mem_rdata;
          rsp_data <= mem_rdata;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        S_ST: begin
          res_addr <= NO_RES;
          if (!same) res_val <= mem_rdata;
          rsp_data <= DW'(flag);
          flag     <= same;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [3:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          done,
  input logic          align_fault,
  input logic          mem_rd,
  input logic          mem_wr
);
  a_r3_misaligned_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_op == 4'b0001 || req_op == 4'b0010) && req_addr[1:0] != 2'b00) |-> !mem_rd);
  a_r3_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> done);
  a_r6_write_in_store_phase: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> busy);
  a_r9_read_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> busy);
  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_rd);
  a_r10_bad_select_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$onehot(req_op)) |=> !done);
  a_r10_read_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (req_valid && $onehot(req_op)));
endmodule

bind excl_monitor excl_monitor_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic        busy, done, align_fault, mem_rd, mem_wr;
  logic [31:0] rsp_data, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  excl_monitor i_excl_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .rsp_data(rsp_data), .align_fault(align_fault), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  logic [31:0] mem [16];
  logic [31:0] mdl [16];
  int rd_cnt = 0, wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr[5:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_rd) begin mem_rdata <= mem[mem_addr[5:2]]; rd_cnt <= rd_cnt + 1; end
  end

  int checks = 0, fails = 0;
  logic [31:0] m_ra = '1, m_rv = '0;
  logic        m_flag = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'b0001: return "R2";
      4'b0010: return "R6";
      4'b0100: return "R4";
      4'b1000: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] data);
    int exp_cyc, exp_rd, exp_wr, cyc, rd0, wr0;
    logic [31:0] exp_rsp;
    logic exp_fault;
    string t;
    exp_rsp = '0; exp_fault = 0; exp_rd = 0; exp_wr = 0; exp_cyc = 1;
    t = tag(op);
    if ((op == 4'b0001 || op == 4'b0010) && addr[1:0] != 2'b00) begin
      exp_fault = 1; t = "R3";
    end else if (op == 4'b0001) begin
      exp_rsp = mdl[addr[5:2]]; m_ra = addr; m_rv = exp_rsp; exp_cyc = 2; exp_rd = 1;
    end else if (op == 4'b0010) begin
      exp_rsp = {31'b0, m_flag};
      if (addr != m_ra) begin
        m_flag = 0; t = "R5";
      end else begin
        exp_rd = 1; exp_cyc = 2; t = "R6";
        if (mdl[addr[5:2]] == m_rv) begin mdl[addr[5:2]] = data; m_flag = 1; exp_wr = 1; end
        else begin m_rv = mdl[addr[5:2]]; m_flag = 0; end
        m_ra = '1;
      end
    end else if (op == 4'b0100) begin
      m_ra = '1;
    end else if (op == 4'b1000) begin
      exp_rsp = {31'b0, m_flag}; m_flag = data[0];
    end else exp_cyc = 0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_data = data;
    @(negedge clk);
    req_valid = 0; req_op = '0;
    cyc = 1;
    while (!done && cyc < 6) begin @(negedge clk); cyc++; end
    if (exp_cyc == 0) chk("R10 no done", {31'b0, done}, 32'd0);
    else begin
      chk({t, " latency"}, cyc, exp_cyc);
      chk({t, " rsp_data"}, rsp_data, exp_rsp);
      chk({t, " align_fault"}, {31'b0, align_fault}, {31'b0, exp_fault});
      @(negedge clk);
      chk("R11 done one cycle", {31'b0, done}, 32'd0);
    end
    chk({t, " reads"}, rd_cnt - rd0, exp_rd);
    chk({t, " writes"}, wr_cnt - wr0, exp_wr);
    chk({t, " memory word"}, mem[addr[5:2]], mdl[addr[5:2]]);
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    mem[idx] = v; mdl[idx] = v;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 16; i++) poke(i, 32'h1000 + i);
    @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
    chk("R1 mem_wr", {31'b0, mem_wr}, 32'd0);
    rst_n = 1;
    run_op(4'b0010, 32'h8, 32'hAA);      // R1: no reservation after reset
    run_op(4'b1000, 32'h0, 32'h1);       // R1 flag 0, R8 set flag
    run_op(4'b1000, 32'h0, 32'h0);       // R8 returns 1
    run_op(4'b0001, 32'h10, 0);          // R2
    run_op(4'b0010, 32'h10, 32'h55);     // R6 success
    run_op(4'b0010, 32'h10, 32'h66);     // R7 reservation dropped
    run_op(4'b0001, 32'h14, 0);
    poke(5, 32'hDEAD);                   // R6 value changed behind monitor
    run_op(4'b0010, 32'h14, 32'h77);
    run_op(4'b0001, 32'h18, 0);
    run_op(4'b0100, 0, 0);               // R4
    run_op(4'b0010, 32'h18, 32'h99);
    run_op(4'b0001, 32'h1C, 0);
    run_op(4'b0010, 32'h1E, 32'h1);      // R3 misaligned store
    run_op(4'b0001, 32'h21, 0);          // R3 misaligned load
    run_op(4'b0010, 32'h1C, 32'h42);     // R3 reservation kept
    run_op(4'b0001, 32'h20, 0);
    run_op(4'b0011, 32'h20, 0);          // R10 two bits set
    run_op(4'b0000, 32'h20, 0);          // R10 none set
    run_op(4'b0010, 32'h20, 32'h5);      // R10 reservation kept
    // R9: clear during busy is ignored
    run_op(4'b0001, 32'h24, 0);
    @(negedge clk);
    req_valid = 1; req_op = 4'b0001; req_addr = 32'h28;
    @(negedge clk);
    chk("R9 busy after read", {31'b0, busy}, 32'd1);
    req_op = 4'b0100;
    @(negedge clk);
    req_valid = 0; req_op = '0;
    m_ra = 32'h28; m_rv = mdl[10];
    chk("R9 load data", rsp_data, mdl[10]);
    @(negedge clk);
    run_op(4'b0010, 32'h28, 32'h123);
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [3:0] op;
      logic [31:0] a;
      r = $urandom_range(0, 9);
      op = (r < 3) ? 4'b0001 : (r < 6) ? 4'b0010 : (r < 7) ? 4'b0100 : 4'b1000;
      a = (m_ra != '1 && $urandom_range(0, 1) == 1) ? m_ra : {26'b0, 4'($urandom), 2'b00};
      if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 7) == 0) poke(int'(a[5:2]), $urandom);
      run_op(op, a, $urandom);
    end
    finish_run();
  end
endmodule